// File: doc/BRIEF.md
# Little-Endian Load/Store Data Aligner

This block sits between a 32-bit register file and a 32-bit memory data bus and performs the lane steering that byte and word transfers need when memory is little-endian. On a load it receives the word read from the bus, the low two bits of the transfer address and a byte/word select. From these it forms the value to write into the destination register. On a store it receives the source register value, the low address bits and the same select. From these it forms the word to drive onto the bus and the per-byte write enables.

A word load from an address that is not word aligned does not fault and does not refetch. The bus word is rotated right so that the addressed byte ends up in the lowest byte of the result. As a consequence, a halfword sitting at byte offset 0 or 2 arrives in the low 16 bits of the register, where software can clear or sign-extend it.

The result passes through one register stage that also carries a valid flag. Each accepted transfer is classified into one of four kinds, which act as the states of that stage: `KIND_LOAD_WORD`, `KIND_LOAD_BYTE`, `KIND_STORE_WORD` and `KIND_STORE_BYTE`. The stage moves from any kind to any other kind on a cycle with `in_valid` high, as selected by `in_is_store` and `in_is_byte`. It stays in its present kind, with its data unchanged, on a cycle with `in_valid` low. Reset puts it in `KIND_LOAD_WORD` with all outputs zero.

Top module: `lsa_aligner`

## Requirements
- R1: A byte load (`in_is_store`=0, `in_is_byte`=1) takes its byte from bus bits 7:0 at offset 0, 15:8 at offset 1, 23:16 at offset 2 and 31:24 at offset 3, where the offset is `in_addr_lo`.
- R2: A byte load places the selected byte in `out_reg_dst` bits 7:0 and drives bits 31:8 to zero.
- R3: A word load (`in_is_store`=0, `in_is_byte`=0) gives the bus word rotated right by 8 times the offset, so that the addressed byte is in bits 7:0; at offset 0 the bus word passes through unchanged.
- R4: A word load of a halfword at offset 0 or offset 2 yields that halfword in `out_reg_dst` bits 15:0.
- R5: A byte store (`in_is_store`=1, `in_is_byte`=1) drives the low 8 bits of `in_reg_src` into all four byte lanes of `out_bus_wr` and sets only bit N of `out_lane_en` for offset N.
- R6: A word store (`in_is_store`=1, `in_is_byte`=0) drives `in_reg_src` unchanged onto `out_bus_wr`, with register bit 31 on bus bit 31, and sets `out_lane_en` to 4'b1111 at every offset.
- R7: After a load, `out_bus_wr` and `out_lane_en` are zero. After a store, `out_reg_dst` is zero.
- R8: `out_valid` is high in the cycle after a clock edge that samples `in_valid` high, and low after an edge that samples it low.
- R9: An edge that samples `in_valid` low leaves `out_reg_dst`, `out_bus_wr` and `out_lane_en` unchanged.
- R10: An active-low `rst_n` clears `out_valid`, `out_reg_dst`, `out_bus_wr` and `out_lane_en` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A transfer is presented this cycle |
| in_is_store | input | 1 | 1 = store, 0 = load |
| in_is_byte | input | 1 | 1 = byte transfer, 0 = word transfer |
| in_addr_lo | input | 2 | Byte offset of the address within the word |
| in_bus_rd | input | 32 | Word read from the memory bus (loads) |
| in_reg_src | input | 32 | Source register value (stores) |
| out_valid | output | 1 | Registered outputs hold a new result |
| out_reg_dst | output | 32 | Aligned value for the destination register |
| out_bus_wr | output | 32 | Word to drive onto the memory bus |
| out_lane_en | output | 4 | Per-byte write enables, bit N for lane N |

## Verification
Every result of the block appears exactly one clock edge after the edge that samples the transfer: the loaded register value, the store bus word and lane enables, and the valid flag. The bench drives each transfer on a falling edge and reads every output on the following falling edge, so that exactly one rising edge lies between the stimulus and the sample. The hold checks keep to the same one-edge spacing. They present changed data with `in_valid` low and read the outputs one falling edge later. The reset checks read the outputs on the falling edge after `rst_n` is driven low.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    // Transfer kinds, encoded {is_store, is_byte}
    typedef enum logic [1:0] {
        KIND_LOAD_WORD  = 2'b00,
        KIND_LOAD_BYTE  = 2'b01,
        KIND_STORE_WORD = 2'b10,
        KIND_STORE_BYTE = 2'b11
    } xfer_kind_e;

    function automatic xfer_kind_e decode_kind(input logic is_store, input logic is_byte);
        return xfer_kind_e'({is_store, is_byte});
    endfunction

    function automatic logic kind_is_store(input xfer_kind_e k);
        return (k == KIND_STORE_WORD) || (k == KIND_STORE_BYTE);
    endfunction

endpackage

// File: rtl/lsa_load_rotator.sv
module lsa_load_rotator #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0]  bus_word,
    input  logic [$clog2(LANES)-1:0] ofs,
    input  logic                     byte_mode,
    output logic [LANES*LANE_W-1:0]  reg_word
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int OFS_W  = $clog2(LANES);

    logic [DATA_W-1:0] rotated;

    // Lane i of the result takes bus lane (i + ofs) mod LANES: a right rotate by ofs lanes
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [OFS_W-1:0] src_idx;
        assign src_idx = OFS_W'(i) + ofs;
        assign rotated[i*LANE_W +: LANE_W] = bus_word[src_idx*LANE_W +: LANE_W];
    end

    // Byte mode keeps only the addressed lane, which the rotate has moved to lane 0
    always_comb begin
        if (byte_mode) begin
            reg_word = '0;
            reg_word[LANE_W-1:0] = rotated[LANE_W-1:0];
        end else begin
            reg_word = rotated;
        end
    end

endmodule

// File: rtl/lsa_store_replicator.sv
module lsa_store_replicator #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0]  src_word,
    input  logic [$clog2(LANES)-1:0] ofs,
    input  logic                     byte_mode,
    output logic [LANES*LANE_W-1:0]  bus_word,
    output logic [LANES-1:0]         lane_en
);
    localparam int OFS_W = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign bus_word[i*LANE_W +: LANE_W] = byte_mode ? src_word[LANE_W-1:0]
                                                        : src_word[i*LANE_W +: LANE_W];
        assign lane_en[i] = byte_mode ? (ofs == OFS_W'(i)) : 1'b1;
    end

endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_is_store,
    input  logic                          in_is_byte,
    input  logic [$clog2(LANES)-1:0]      in_addr_lo,
    input  logic [LANES*LANE_W-1:0]       in_bus_rd,
    input  logic [LANES*LANE_W-1:0]       in_reg_src,
    output logic                          out_valid,
    output logic [LANES*LANE_W-1:0]       out_reg_dst,
    output logic [LANES*LANE_W-1:0]       out_bus_wr,
    output logic [LANES-1:0]              out_lane_en
);
    import lsa_pkg::*;

    localparam int DATA_W = LANES * LANE_W;

    xfer_kind_e        in_kind;
    xfer_kind_e        kind_q, kind_d;
    logic [DATA_W-1:0] ld_word, st_word;
    logic [LANES-1:0]  st_en;
    logic [DATA_W-1:0] dst_d, wr_d;
    logic [LANES-1:0]  en_d;

    assign in_kind = decode_kind(in_is_store, in_is_byte);

    lsa_load_rotator #(.LANES(LANES), .LANE_W(LANE_W)) u_load (
        .bus_word  (in_bus_rd),
        .ofs       (in_addr_lo),
        .byte_mode (in_is_byte),
        .reg_word  (ld_word)
    );

    lsa_store_replicator #(.LANES(LANES), .LANE_W(LANE_W)) u_store (
        .src_word  (in_reg_src),
        .ofs       (in_addr_lo),
        .byte_mode (in_is_byte),
        .bus_word  (st_word),
        .lane_en   (st_en)
    );

    // Next-value process: kind is held when no transfer is presented
    always_comb begin
        kind_d = kind_q;
        dst_d  = out_reg_dst;
        wr_d   = out_bus_wr;
        en_d   = out_lane_en;
        if (in_valid) begin
            kind_d = in_kind;
            unique case (in_kind)
                KIND_LOAD_WORD, KIND_LOAD_BYTE: begin
                    dst_d = ld_word;
                    wr_d  = '0;
                    en_d  = '0;
                end
                KIND_STORE_WORD, KIND_STORE_BYTE: begin
                    dst_d = '0;
                    wr_d  = st_word;
                    en_d  = st_en;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q      <= KIND_LOAD_WORD;
            out_valid   <= 1'b0;
            out_reg_dst <= '0;
            out_bus_wr  <= '0;
            out_lane_en <= '0;
        end else begin
            kind_q      <= kind_d;
            out_valid   <= in_valid;
            out_reg_dst <= dst_d;
            out_bus_wr  <= wr_d;
            out_lane_en <= en_d;
        end
    end

    assert_valid_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_reg_dst) && $stable(out_bus_wr) && $stable(out_lane_en)));

    assert_byte_zext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == KIND_LOAD_BYTE) |-> (out_reg_dst[DATA_W-1:LANE_W] == '0));

    assert_byte_lane_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == KIND_STORE_BYTE) |-> ($countones(out_lane_en) == 1));

    assert_word_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_store && !in_is_byte)
        |=> ((out_bus_wr == $past(in_reg_src)) && (&out_lane_en)));

    assert_load_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !kind_is_store(kind_q) |-> ((out_bus_wr == '0) && (out_lane_en == '0)));

    assert_store_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        kind_is_store(kind_q) |-> (out_reg_dst == '0));

endmodule

// File: tb/test_lsa_aligner.sv
module test_lsa_aligner;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 16;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_is_store = 1'b0;
    logic        in_is_byte = 1'b0;
    logic [1:0]  in_addr_lo = 2'd0;
    logic [31:0] in_bus_rd = 32'h0;
    logic [31:0] in_reg_src = 32'h0;
    logic        out_valid;
    logic [31:0] out_reg_dst;
    logic [31:0] out_bus_wr;
    logic [3:0]  out_lane_en;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsa_aligner i_lsa_aligner (
        .clk, .rst_n, .in_valid, .in_is_store, .in_is_byte, .in_addr_lo,
        .in_bus_rd, .in_reg_src, .out_valid, .out_reg_dst, .out_bus_wr, .out_lane_en
    );

    // {store, byte, offset, bus_rd, reg_src, exp_dst, exp_wr, exp_en}
    localparam logic [135:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 2'd0, 32'hA1B2C3D4, 32'h0, 32'h000000D4, 32'h0, 4'h0}, // R1 R2
        {1'b0, 1'b1, 2'd1, 32'hA1B2C3D4, 32'h0, 32'h000000C3, 32'h0, 4'h0}, // R1 R2
        {1'b0, 1'b1, 2'd2, 32'hA1B2C3D4, 32'h0, 32'h000000B2, 32'h0, 4'h0}, // R1 R2
        {1'b0, 1'b1, 2'd3, 32'hA1B2C3D4, 32'h0, 32'h000000A1, 32'h0, 4'h0}, // R1 R2
        {1'b0, 1'b0, 2'd0, 32'hA1B2C3D4, 32'h0, 32'hA1B2C3D4, 32'h0, 4'h0}, // R3
        {1'b0, 1'b0, 2'd1, 32'hA1B2C3D4, 32'h0, 32'hD4A1B2C3, 32'h0, 4'h0}, // R3
        {1'b0, 1'b0, 2'd2, 32'hA1B2C3D4, 32'h0, 32'hC3D4A1B2, 32'h0, 4'h0}, // R3
        {1'b0, 1'b0, 2'd3, 32'hA1B2C3D4, 32'h0, 32'hB2C3D4A1, 32'h0, 4'h0}, // R3
        {1'b0, 1'b0, 2'd0, 32'h1234ABCD, 32'h0, 32'h1234ABCD, 32'h0, 4'h0}, // R4
        {1'b0, 1'b0, 2'd2, 32'h1234ABCD, 32'h0, 32'hABCD1234, 32'h0, 4'h0}, // R4
        {1'b1, 1'b1, 2'd0, 32'hFFFFFFFF, 32'h55667788, 32'h0, 32'h88888888, 4'h1}, // R5 R7
        {1'b1, 1'b1, 2'd1, 32'hFFFFFFFF, 32'h55667788, 32'h0, 32'h88888888, 4'h2}, // R5
        {1'b1, 1'b1, 2'd2, 32'hFFFFFFFF, 32'h55667788, 32'h0, 32'h88888888, 4'h4}, // R5
        {1'b1, 1'b1, 2'd3, 32'hFFFFFFFF, 32'h55667788, 32'h0, 32'h88888888, 4'h8}, // R5
        {1'b1, 1'b0, 2'd0, 32'h0, 32'hDEADBEEF, 32'h0, 32'hDEADBEEF, 4'hF}, // R6
        {1'b1, 1'b0, 2'd3, 32'h0, 32'h80000001, 32'h0, 32'h80000001, 4'hF}  // R6
    };

    function automatic string vec_tag(input int i);
        if (i < 4)  return "R1/R2";
        if (i < 8)  return "R3";
        if (i < 10) return "R4";
        if (i < 14) return "R5";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic st, input logic by, input logic [1:0] ofs,
                         input logic [31:0] bus, input logic [31:0] src);
        in_valid    = v;
        in_is_store = st;
        in_is_byte  = by;
        in_addr_lo  = ofs;
        in_bus_rd   = bus;
        in_reg_src  = src;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R8: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] held_dst, held_wr;
        logic [3:0]  held_en;

        // R10: outputs during reset
        repeat (2) @(negedge clk);
        check("R10 valid", {31'b0, out_valid}, 32'h0);
        check("R10 dst", out_reg_dst, 32'h0);
        check("R10 wr", out_bus_wr, 32'h0);
        check("R10 en", {28'b0, out_lane_en}, 32'h0);
        rst_n = 1'b1;

        // Vector table: one edge between drive and sample
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(1'b1, VEC[i][135], VEC[i][134], VEC[i][133:132], VEC[i][131:100], VEC[i][99:68]);
            @(negedge clk);
            check({vec_tag(i), " dst"}, out_reg_dst, VEC[i][67:36]);
            check({vec_tag(i), " wr (R7)"}, out_bus_wr, VEC[i][35:4]);
            check({vec_tag(i), " en (R7)"}, {28'b0, out_lane_en}, {28'b0, VEC[i][3:0]});
            check("R8 valid high", {31'b0, out_valid}, 32'h1);
        end

        // R4: halfword at offset 2 lands in 15:0
        drive(1'b1, 1'b0, 1'b0, 2'd2, 32'hBEEF0000, 32'h0);
        @(negedge clk);
        check("R4 half hi", {16'h0, out_reg_dst[15:0]}, 32'h0000BEEF);

        // R9: idle cycles with changed inputs leave data alone
        held_dst = out_reg_dst;
        held_wr  = out_bus_wr;
        held_en  = out_lane_en;
        drive(1'b0, 1'b1, 1'b1, 2'd1, 32'h13579BDF, 32'h2468ACE0);
        @(negedge clk);
        check("R8 valid low", {31'b0, out_valid}, 32'h0);
        check("R9 dst held", out_reg_dst, held_dst);
        check("R9 wr held", out_bus_wr, held_wr);
        check("R9 en held", {28'b0, out_lane_en}, {28'b0, held_en});
        drive(1'b0, 1'b0, 1'b0, 2'd3, 32'hFFFFFFFF, 32'hFFFFFFFF);
        @(negedge clk);
        check("R9 dst held 2", out_reg_dst, held_dst);

        // R7: store after load clears the register result
        drive(1'b1, 1'b1, 1'b0, 2'd1, 32'hFFFFFFFF, 32'h0BADF00D);
        @(negedge clk);
        check("R7 dst zero on store", out_reg_dst, 32'h0);
        check("R6 word store offset1", out_bus_wr, 32'h0BADF00D);
        check("R6 en offset1", {28'b0, out_lane_en}, 32'hF);

        // R10: mid-run reset
        drive(1'b1, 1'b0, 1'b1, 2'd3, 32'h7F000000, 32'h0);
        @(negedge clk);
        check("R1 top lane", out_reg_dst, 32'h0000007F);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid valid", {31'b0, out_valid}, 32'h0);
        check("R10 mid dst", out_reg_dst, 32'h0);
        drive(1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after release valid", {31'b0, out_valid}, 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule